// File: doc/BRIEF.md
# Integer-Ratio Sync Pulse Generator

This block runs entirely on a fast core clock. It divides that clock by a programmable integer ratio to make a slow I/O-rate clock. A second, independently programmed ratio makes a double-rate clock. For every slow period it produces single-cycle enable pulses. Core-domain flops use these pulses to launch data toward the slow domain (fast-to-slow), to capture data coming from it (slow-to-fast), and to exchange data with the double-rate domain.

Each enable sits at a fixed phase of its slow period, and that phase depends on a placement mode. Normal placement puts the pulses two fast half-periods after a slow clock edge. Deterministic-test placement moves the slow-to-fast pulse to just before the next slow rising edge and centres the fast-to-slow pulse in the slow period. Ratios and mode are captured only while reset is held.

Asserting clock-stop or reset silences every output. After release, every output restarts from phase zero. A build-time option makes the fast-to-slow output carry the double-rate enable, for clusters that have no separate double-rate port.

Top module: `sync_pulse_gen`

## Requirements
- R1: `io_ratio` and `x2_ratio` are captured only on clock edges where `rst_n` is low. A captured `io_ratio` below 3 becomes 3, and a captured `x2_ratio` below 2 becomes 2. Later changes to these inputs have no effect until the next reset.
- R2: Phase p counts fast cycles from the first cycle after release of the hold (p = 0), modulo the captured ratio R. `io_clk` is 1 for p < floor(R/2) and 0 otherwise. `x2_clk` follows the same rule using its own counter and ratio R2.
- R3: Each enable is high for exactly one fast cycle and pulses exactly once in every R consecutive fast cycles of its domain.
- R4: With normal placement (`test_mode` captured as 0), `s2f_en` is high at io phase 1: the fast cycle ending at the fast rising edge after the second fast falling edge following an `io_clk` rise.
- R5: With normal placement, `f2s_en` is high at io phase floor(R/2)+1: the fast cycle ending at the rising edge after the second fast falling edge following an `io_clk` fall.
- R6: With test placement (`test_mode` captured as 1), `s2f_en` is high at io phase R-2. After one flop stage it is therefore high in the cycle just before the next `io_clk` rise.
- R7: With test placement, `f2s_en` is high at io phase floor((R-3)/2). After one flop stage it falls within one fast period of the middle of the slow period.
- R8: `x2_en` is high at double-rate phase floor(R2/2): the first fast cycle with `x2_clk` low. This holds in both placements.
- R9: While `rst_n` is low or `clk_stop` is high, all five outputs are 0. In the first fast cycle after release, both counters are at phase 0 and both divided clocks are 1.
- R10: `test_mode` is captured only while `rst_n` is low. Changing it afterwards has no effect.
- R11: With parameter `F2S_CARRIES_X2` = 1, `f2s_en` carries the double-rate enable of R8 instead of the enable of R5 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast core clock |
| rst_n | input | 1 | synchronous active-low reset; configuration capture window |
| clk_stop | input | 1 | holds all outputs low and parks the counters at phase 0 |
| test_mode | input | 1 | placement select, 1 = deterministic-test placement |
| io_ratio | input | 8 | fast cycles per I/O-rate period |
| x2_ratio | input | 8 | fast cycles per double-rate period |
| io_clk | output | 1 | divided I/O-rate clock |
| x2_clk | output | 1 | divided double-rate clock |
| f2s_en | output | 1 | fast-to-slow launch enable |
| s2f_en | output | 1 | slow-to-fast capture enable |
| x2_en | output | 1 | double-rate enable |

## Verification
A corrupted phase counter or captured ratio shows up in the same cycle as a shifted `io_clk` edge or a misplaced enable. Every output is compared each cycle against phases computed independently, so a fault is caught within one slow period. A configuration that leaks while running shows as a changed period within a few cycles, because the ratio and mode inputs are re-randomised on every running cycle. A hold that fails to restart the counters shows in the first cycle after release, because `io_clk` must then be 1 and the enables must sit at their phase-0 values.

// File: rtl/syncgen_pkg.sv
package syncgen_pkg;

  localparam int RATIO_W = 8;
  localparam int N_CH    = 3;
  localparam int CH_F2S  = 0;
  localparam int CH_S2F  = 1;
  localparam int CH_X2   = 2;

  typedef logic [RATIO_W-1:0] ratio_t;

  // Raise a programmed ratio to the supported floor.
  function automatic ratio_t clamp_ratio(ratio_t r, ratio_t lo);
    return (r < lo) ? lo : r;
  endfunction

  // Number of leading high phases of a divided clock.
  function automatic ratio_t high_len(ratio_t r);
    return r >> 1;
  endfunction

  // Phase of the slow-to-fast enable.
  function automatic ratio_t s2f_slot(ratio_t r, logic dtm);
    return dtm ? ratio_t'(r - ratio_t'(2)) : ratio_t'(1);
  endfunction

  // Phase of the fast-to-slow enable.
  function automatic ratio_t f2s_slot(ratio_t r, logic dtm);
    return dtm ? ratio_t'((r - ratio_t'(3)) >> 1) : ratio_t'((r >> 1) + ratio_t'(1));
  endfunction

  // Phase of the double-rate enable: first low phase of its clock.
  function automatic ratio_t x2_slot(ratio_t r);
    return r >> 1;
  endfunction

endpackage

// File: rtl/syncgen_cfg.sv
module syncgen_cfg
  import syncgen_pkg::*;
#(
  parameter ratio_t IO_MIN = 8'd3,
  parameter ratio_t X2_MIN = 8'd2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t io_ratio_i,
  input  ratio_t x2_ratio_i,
  input  logic   mode_i,
  output ratio_t io_r_o,
  output ratio_t x2_r_o,
  output logic   dtm_o
);

  // Capture window is the reset interval only.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_r_o <= clamp_ratio(io_ratio_i, IO_MIN);
      x2_r_o <= clamp_ratio(x2_ratio_i, X2_MIN);
      dtm_o  <= mode_i;
    end
  end

  assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(io_r_o) && $stable(x2_r_o)));

  assert_cfg_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (io_r_o >= IO_MIN && x2_r_o >= X2_MIN));

  assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(dtm_o));

endmodule

// File: rtl/syncgen_phase.sv
module syncgen_phase
  import syncgen_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hold_i,
  input  ratio_t ratio_i,
  output ratio_t ph_nxt_o,
  output ratio_t ph_o,
  output logic   div_clk_o
);

  logic run_q;
  logic at_last_w;

  assign at_last_w = (ph_o == ratio_i - 1'b1);

  always_comb begin
    if (!run_q || at_last_w) ph_nxt_o = '0;
    else                     ph_nxt_o = ph_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (hold_i) begin
      run_q     <= 1'b0;
      ph_o      <= '0;
      div_clk_o <= 1'b0;
    end else begin
      run_q     <= 1'b1;
      ph_o      <= ph_nxt_o;
      div_clk_o <= (ph_nxt_o < high_len(ratio_i));
    end
  end

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ph_o < ratio_i);

  assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (!div_clk_o && ph_o == '0));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold_i) && !hold_i) |=> (div_clk_o && ph_o == '0));

endmodule

// File: rtl/syncgen_strobe.sv
module syncgen_strobe
  import syncgen_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hold_i,
  input  ratio_t ph_nxt_i,
  input  ratio_t slot_i,
  input  ratio_t ratio_i,
  output logic   en_o
);

  logic hit_w;
  assign hit_w = (ph_nxt_i == slot_i);

  always_ff @(posedge clk) begin
    en_o <= !hold_i && hit_w;
  end

  // Checker state: distance since the previous pulse.
  ratio_t gap_q;
  logic   seen_q;

  always_ff @(posedge clk) begin
    if (hold_i) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (en_o) begin
      gap_q  <= ratio_t'(1);
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  assert_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |=> !en_o);

  assert_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && seen_q) |-> (gap_q == ratio_i));

  assert_strobe_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !en_o);

endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
  import syncgen_pkg::*;
#(
  parameter ratio_t IO_MIN         = 8'd3,
  parameter ratio_t X2_MIN         = 8'd2,
  parameter bit     F2S_CARRIES_X2 = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_stop,
  input  logic               test_mode,
  input  logic [RATIO_W-1:0] io_ratio,
  input  logic [RATIO_W-1:0] x2_ratio,
  output logic               io_clk,
  output logic               x2_clk,
  output logic               f2s_en,
  output logic               s2f_en,
  output logic               x2_en
);

  logic   hold_w;
  ratio_t io_r, x2_r;
  logic   dtm;
  ratio_t io_nxt, io_ph, x2_nxt, x2_ph;

  assign hold_w = !rst_n || clk_stop;

  syncgen_cfg #(.IO_MIN(IO_MIN), .X2_MIN(X2_MIN)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_ratio_i (io_ratio),
    .x2_ratio_i (x2_ratio),
    .mode_i     (test_mode),
    .io_r_o     (io_r),
    .x2_r_o     (x2_r),
    .dtm_o      (dtm)
  );

  syncgen_phase u_io_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (hold_w),
    .ratio_i   (io_r),
    .ph_nxt_o  (io_nxt),
    .ph_o      (io_ph),
    .div_clk_o (io_clk)
  );

  syncgen_phase u_x2_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (hold_w),
    .ratio_i   (x2_r),
    .ph_nxt_o  (x2_nxt),
    .ph_o      (x2_ph),
    .div_clk_o (x2_clk)
  );

  // Per-channel phase source, slot and ratio.
  ratio_t ch_ph    [N_CH];
  ratio_t ch_slot  [N_CH];
  ratio_t ch_ratio [N_CH];
  logic   ch_en    [N_CH];

  always_comb begin
    ch_ph[CH_S2F]    = io_nxt;
    ch_slot[CH_S2F]  = s2f_slot(io_r, dtm);
    ch_ratio[CH_S2F] = io_r;
    ch_ph[CH_X2]     = x2_nxt;
    ch_slot[CH_X2]   = x2_slot(x2_r);
    ch_ratio[CH_X2]  = x2_r;
    if (F2S_CARRIES_X2) begin
      ch_ph[CH_F2S]    = x2_nxt;
      ch_slot[CH_F2S]  = x2_slot(x2_r);
      ch_ratio[CH_F2S] = x2_r;
    end else begin
      ch_ph[CH_F2S]    = io_nxt;
      ch_slot[CH_F2S]  = f2s_slot(io_r, dtm);
      ch_ratio[CH_F2S] = io_r;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    syncgen_strobe u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_i   (hold_w),
      .ph_nxt_i (ch_ph[g]),
      .slot_i   (ch_slot[g]),
      .ratio_i  (ch_ratio[g]),
      .en_o     (ch_en[g])
    );
  end

  assign f2s_en = ch_en[CH_F2S];
  assign s2f_en = ch_en[CH_S2F];
  assign x2_en  = ch_en[CH_X2];

  // Phase counters stay inside their periods (debug view of internal state).
  assert_ph_bounds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_ph < io_r) && (x2_ph < x2_r));

  assert_s2f_after_rise_R4: assert property (@(posedge clk) disable iff (hold_w)
    (s2f_en && !dtm) |-> $past(io_clk));

  assert_s2f_before_rise_R6: assert property (@(posedge clk) disable iff (hold_w)
    (s2f_en && dtm) |=> (!io_clk && !s2f_en));

  assert_x2_first_low_R8: assert property (@(posedge clk) disable iff (hold_w)
    x2_en |-> (!x2_clk && $past(x2_clk)));

  if (F2S_CARRIES_X2) begin : g_f2s_x2
    assert_f2s_carries_x2_R11: assert property (@(posedge clk) disable iff (!rst_n)
      f2s_en == x2_en);
  end else begin : g_f2s_io
    assert_f2s_after_fall_R5: assert property (@(posedge clk) disable iff (hold_w)
      (f2s_en && !dtm) |-> (!io_clk && !$past(io_clk)));
  end

endmodule

// File: tb/test_sync_pulse_gen.sv
`timescale 1ns/1ps
module test_sync_pulse_gen;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0, clk_stop = 1'b0, test_mode = 1'b0;
  logic [7:0] io_ratio = 8'd4, x2_ratio = 8'd2;
  logic io_clk_a, x2_clk_a, f2s_a, s2f_a, x2en_a;
  logic io_clk_b, x2_clk_b, f2s_b, s2f_b, x2en_b;

  sync_pulse_gen i_sync_pulse_gen (
    .clk(clk), .rst_n(rst_n), .clk_stop(clk_stop), .test_mode(test_mode),
    .io_ratio(io_ratio), .x2_ratio(x2_ratio),
    .io_clk(io_clk_a), .x2_clk(x2_clk_a), .f2s_en(f2s_a), .s2f_en(s2f_a), .x2_en(x2en_a)
  );

  sync_pulse_gen #(.F2S_CARRIES_X2(1'b1)) i_sync_pulse_gen_x2 (
    .clk(clk), .rst_n(rst_n), .clk_stop(clk_stop), .test_mode(test_mode),
    .io_ratio(io_ratio), .x2_ratio(x2_ratio),
    .io_clk(io_clk_b), .x2_clk(x2_clk_b), .f2s_en(f2s_b), .s2f_en(s2f_b), .x2_en(x2en_b)
  );

  int n_cmp = 0, n_bad = 0;
  int e_r = 3, e_r2 = 2, k = 0;
  bit e_dtm = 0, live = 0, done = 0;

  task automatic chk(input string req, input string sig, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (ratio %0d/%0d mode %0d step %0d)",
               req, sig, act, exp, e_r, e_r2, e_dtm, k);
    end
  endtask

  function automatic int floor_clamp(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

  // Where each pulse must sit, phrased from the requirements.
  function automatic int want_s2f(input int p, input int r, input bit dtm);
    if (dtm) return int'(p == r - 2);   // R6
    return int'(p == 1);                // R4
  endfunction

  function automatic int want_f2s(input int p, input int r, input bit dtm);
    if (dtm) return int'(2 * p == r - 3 || 2 * p == r - 4); // R7: floor((r-3)/2)
    return int'(p == r / 2 + 1);                             // R5
  endfunction

  task automatic compare();
    if (!live) begin
      chk("R9", "io_clk", io_clk_a, 0);
      chk("R9", "x2_clk", x2_clk_a, 0);
      chk("R9", "s2f_en", s2f_a, 0);
      chk("R9", "f2s_en", f2s_a, 0);
      chk("R9", "x2_en", x2en_a, 0);
      chk("R9", "f2s_en option", f2s_b, 0);
    end else begin
      int p = k % e_r;
      int q = k % e_r2;
      chk("R2", "io_clk", io_clk_a, int'(2 * p < e_r - (e_r % 2)));
      chk("R2", "x2_clk", x2_clk_a, int'(2 * q < e_r2 - (e_r2 % 2)));
      chk(e_dtm ? "R6" : "R4", "s2f_en", s2f_a, want_s2f(p, e_r, e_dtm));
      chk(e_dtm ? "R7" : "R5", "f2s_en", f2s_a, want_f2s(p, e_r, e_dtm));
      chk("R8", "x2_en", x2en_a, int'(q == e_r2 / 2));
      chk("R11", "f2s_en option", f2s_b, int'(q == e_r2 / 2));
    end
  endtask

  // One fast cycle: model the edge, then compare away from it.
  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      e_r   = floor_clamp(int'(io_ratio), 3);
      e_r2  = floor_clamp(int'(x2_ratio), 2);
      e_dtm = test_mode;
    end
    if (!rst_n || clk_stop) live = 0;
    else if (!live) begin live = 1; k = 0; end
    else k++;
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset(input int r, input int r2, input bit m);
    io_ratio = 8'(r); x2_ratio = 8'(r2); test_mode = m;
    rst_n = 1'b0; clk_stop = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);

    // Mixed directed corners and random configurations; R1 and R10 are exercised
    // by re-randomising the ratio and mode inputs on every running cycle.
    for (int t = 0; t < 40; t++) begin
      int r, r2; bit m;
      r  = 3 + $urandom_range(0, 11);
      r2 = $urandom_range(0, 9);
      m  = 1'($urandom_range(0, 1));
      if (t == 0) begin r = 3; m = 0; end
      if (t == 1) begin r = 3; m = 1; end
      if (t == 2) begin r = 1; r2 = 0; end
      if (t == 3) begin r = 255; r2 = 3; m = 0; end
      do_reset(r, r2, m);
      for (int c = 0; c < ((t == 3) ? 600 : 80); c++) begin
        clk_stop  = ($urandom_range(0, 29) == 0);
        io_ratio  = 8'($urandom_range(0, 255));
        x2_ratio  = 8'($urandom_range(0, 255));
        test_mode = 1'($urandom_range(0, 1));
        step();
      end
      clk_stop = 1'b0;
    end

    // R1: programmed ratios below the floor are raised to 3 and 2.
    begin
      int last_rise = -1, per = 0, last2 = -1, per2 = 0;
      bit prev = 0, prev2 = 0;
      do_reset(1, 0, 0);
      for (int c = 0; c < 20; c++) begin
        step();
        if (io_clk_a && !prev) begin if (last_rise >= 0) per = c - last_rise; last_rise = c; end
        if (x2_clk_a && !prev2) begin if (last2 >= 0) per2 = c - last2; last2 = c; end
        prev = io_clk_a; prev2 = x2_clk_a;
      end
      chk("R1", "io period after clamp", per, 3);
      chk("R1", "x2 period after clamp", per2, 2);
    end

    // R10: mode flipped after reset keeps normal placement of s2f at phase 1.
    begin
      int hit = -1;
      do_reset(6, 4, 0);
      test_mode = 1'b1;
      for (int c = 0; c < 6; c++) begin step(); if (s2f_a && hit < 0) hit = c; end
      chk("R10", "s2f phase with mode changed", hit, 1);
    end

    // R3: exactly one pulse per window of R cycles and never two in a row.
    begin
      int n_s = 0, n_f = 0, dbl = 0; bit ps = 0;
      do_reset(5, 3, 1);
      step(); step();
      for (int c = 0; c < 20; c++) begin
        step();
        n_s += s2f_a; n_f += f2s_a;
        if (s2f_a && ps) dbl++;
        ps = s2f_a;
      end
      chk("R3", "s2f pulses in 4 periods", n_s, 4);
      chk("R3", "f2s pulses in 4 periods", n_f, 4);
      chk("R3", "back-to-back s2f", dbl, 0);
    end

    // R9: clock-stop mid-period, then restart from phase 0.
    begin
      do_reset(7, 3, 0);
      repeat (4) step();
      clk_stop = 1'b1;
      repeat (3) step();
      clk_stop = 1'b0;
      step();
      chk("R9", "io_clk first cycle after stop", io_clk_a, 1);
      chk("R9", "x2_clk first cycle after stop", x2_clk_a, 1);
      repeat (10) step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule